// File: doc/BRIEF.md
# Prescaled Interval Timer

This block raises periodic interrupts. A 16-bit down-counter is stepped by a programmable clock divider, and the processor can write three values: the counter itself, a divider setting and a reload period. The divider setting holds one less than the division ratio. With the default 8-bit divider field, the counter therefore steps once every 1 to 256 clock cycles.

When a step finds the counter already at zero, the counter reloads from the period value. When a step takes the counter from one to zero, the block emits a single-cycle interrupt pulse. A period of zero makes the counter sit at zero, and an interrupt is produced on every step. A running timer with period P and divider setting S interrupts once every (P+1)·(S+1) enabled cycles. A low enable freezes both the divider and the counter. Interrupt routing and register address decoding belong to the surrounding logic.

Top module: `itmr_top`

## Requirements
- R1: While reset is asserted, and after it is released, `count_o` reads 0 and `irq_o` reads 0 until the timer first steps.
- R2: A pulse on `wr_scale` stores `wr_data[7:0]` as divider setting S. With enable high, the counter then steps once every S+1 cycles.
- R3: A divider setting of 0 steps the counter on every enabled cycle.
- R4: `irq_o` is high for exactly the one cycle in which `count_o` first shows 0 after a step from 1, and is otherwise low, except as stated in R6.
- R5: A step taken while the counter is 0 loads the period value (`wr_data` captured by `wr_period`) into the counter. For a period P, consecutive interrupts are then (P+1)·(S+1) enabled cycles apart.
- R6: With period 0, every step produces an interrupt and the counter stays at 0.
- R7: A pulse on `wr_count` loads `wr_data` into the counter in the next cycle. This load overrides a step in the same cycle, produces no interrupt, and restarts the divider, so the next step comes S+1 enabled cycles later.
- R8: While `enable` is low, `count_o` and the divider position hold, and `irq_o` stays low. Counting resumes from the held position.
- R9: Writing the period does not change the counter. The new value takes effect at the next reload.
- R10: Writing the divider setting restarts the divider from the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Timer run enable |
| wr_count | input | 1 | Write strobe for the counter |
| wr_scale | input | 1 | Write strobe for the divider setting (low 8 bits of data) |
| wr_period | input | 1 | Write strobe for the reload period |
| wr_data | input | 16 | Write data shared by all strobes |
| count_o | output | 16 | Current counter value |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
Every result is due one edge after its cause. A counter write is visible in the next cycle. A step happens on the edge that closes the (S+1)-th enabled cycle after the last divider restart, and the new count and any interrupt appear together just after that edge. The bench drives inputs one nanosecond after each rising edge and samples just after the next rising edge. It counts k enabled cycles from the counter write and predicts the expected value arithmetically: it derives the number of steps t = floor(k/(S+1)), then the count and interrupt from t, the written count and the period. Cycles with enable held low are excluded from k.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

   // Action selected for the counter register in a given cycle.
   typedef enum logic [1:0] {
      ACT_HOLD   = 2'd0,
      ACT_LOAD   = 2'd1,
      ACT_STEP   = 2'd2,
      ACT_RELOAD = 2'd3
   } cnt_act_e;

endpackage

// File: rtl/itmr_regs.sv
module itmr_regs #(
   parameter int CNT_W = 16,
   parameter int SCL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_scale,
   input  logic             wr_period,
   input  logic [CNT_W-1:0] wr_data,
   output logic [SCL_W-1:0] scale_q,
   output logic [CNT_W-1:0] period_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scale_q  <= '0;
         period_q <= '0;
      end else begin
         if (wr_scale)  scale_q  <= wr_data[SCL_W-1:0];
         if (wr_period) period_q <= wr_data;
      end
   end

endmodule

// File: rtl/itmr_prescale.sv
module itmr_prescale #(
   parameter int SCL_W        = 8,
   parameter bit HAS_PRESCALE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             restart,
   input  logic [SCL_W-1:0] restart_val,
   input  logic [SCL_W-1:0] scale,
   output logic             tick_o
);

   generate
      if (HAS_PRESCALE) begin : g_div
         logic [SCL_W-1:0] pos_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pos_q <= '0;
            end else if (restart) begin
               pos_q <= restart_val;
            end else if (enable) begin
               if (pos_q == '0) pos_q <= scale;
               else             pos_q <= pos_q - SCL_W'(1);
            end
         end

         assign tick_o = enable && (pos_q == '0);
      end else begin : g_nodiv
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ restart ^ (^restart_val) ^ (^scale);
         assign tick_o    = enable;
      end
   endgenerate

endmodule

// File: rtl/itmr_count.sv
module itmr_count
   import itmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] count_q,
   output logic             irq_q
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   cnt_act_e   act;
   logic       at_zero;
   logic       irq_nxt;

   assign at_zero = (count_q == '0);

   always_comb begin
      if (load)              act = ACT_LOAD;
      else if (tick && !at_zero) act = ACT_STEP;
      else if (tick)         act = ACT_RELOAD;
      else                   act = ACT_HOLD;
   end

   always_comb begin
      unique case (act)
         ACT_STEP:   irq_nxt = (count_q == ONE);
         ACT_RELOAD: irq_nxt = (period == '0);
         default:    irq_nxt = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= irq_nxt;
         unique case (act)
            ACT_LOAD:   count_q <= load_val;
            ACT_STEP:   count_q <= count_q - ONE;
            ACT_RELOAD: count_q <= period;
            default:    count_q <= count_q;
         endcase
      end
   end

endmodule

// File: rtl/itmr_top.sv
module itmr_top #(
   parameter int CNT_W        = 16,
   parameter int SCL_W        = 8,
   parameter bit HAS_PRESCALE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             wr_count,
   input  logic             wr_scale,
   input  logic             wr_period,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] count_o,
   output logic             irq_o
);

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("itmr_top: CNT_W must be at least 2");
      end
      if (SCL_W < 1 || SCL_W > CNT_W) begin : g_bad_scl
         $error("itmr_top: SCL_W must lie in 1..CNT_W");
      end
   endgenerate

   logic [SCL_W-1:0] scale_q;
   logic [CNT_W-1:0] period_q;
   logic             div_restart;
   logic [SCL_W-1:0] div_start;
   logic             tick;

   itmr_regs #(
      .CNT_W (CNT_W),
      .SCL_W (SCL_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_scale  (wr_scale),
      .wr_period (wr_period),
      .wr_data   (wr_data),
      .scale_q   (scale_q),
      .period_q  (period_q)
   );

   // A scale write restarts from the new value; a count write from the held one.
   assign div_restart = wr_count | wr_scale;
   assign div_start   = wr_scale ? wr_data[SCL_W-1:0] : scale_q;

   itmr_prescale #(
      .SCL_W        (SCL_W),
      .HAS_PRESCALE (HAS_PRESCALE)
   ) u_div (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (enable),
      .restart     (div_restart),
      .restart_val (div_start),
      .scale       (scale_q),
      .tick_o      (tick)
   );

   itmr_count #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load     (wr_count),
      .load_val (wr_data),
      .period   (period_q),
      .count_q  (count_o),
      .irq_q    (irq_o)
   );

endmodule

// File: rtl/itmr_chk.sv
module itmr_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic             wr_count,
   input logic [CNT_W-1:0] wr_data,
   input logic [CNT_W-1:0] count_o,
   input logic             irq_o
);

   assert_irq_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (count_o == '0));

   assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_count |=> (count_o == $past(wr_data)) && !irq_o);

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !wr_count) |=> $stable(count_o) && !irq_o);

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_count && count_o != '0) |=>
         (count_o == $past(count_o)) || (count_o == $past(count_o) - CNT_W'(1)));

   assert_irq_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(enable));

endmodule

bind itmr_top itmr_chk #(.CNT_W(CNT_W)) u_itmr_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .enable   (enable),
   .wr_count (wr_count),
   .wr_data  (wr_data),
   .count_o  (count_o),
   .irq_o    (irq_o)
);

// File: tb/test_itmr_top.sv
`timescale 1ns/1ps
module test_itmr_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        wr_count = 1'b0;
   logic        wr_scale = 1'b0;
   logic        wr_period = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] count_o;
   logic        irq_o;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   itmr_top i_itmr_top (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .wr_count  (wr_count),
      .wr_scale  (wr_scale),
      .wr_period (wr_period),
      .wr_data   (wr_data),
      .count_o   (count_o),
      .irq_o     (irq_o)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         failures++;
         $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<150000", cycles);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input int sel, input int data);
      wr_data = 16'(data);
      wr_count  = (sel == 0);
      wr_scale  = (sel == 1);
      wr_period = (sel == 2);
      step();
      wr_count = 1'b0; wr_scale = 1'b0; wr_period = 1'b0;
   endtask

   // Expected count after t steps from a written value c with period p.
   function automatic int exp_cnt(int c, int p, int t);
      if (t <= c) return c - t;
      return p - ((t - c - 1) % (p + 1));
   endfunction

   function automatic bit exp_irq_at(int c, int p, int t);
      if (t == 0) return 1'b0;
      if (t == c && c > 0) return 1'b1;
      return (t > c) && (((t - c) % (p + 1)) == 0);
   endfunction

   task automatic run_case(input int s, input int p, input int c, input int hold_at);
      int n;
      int held;
      wr(1, s);
      wr(2, p);
      wr(0, c);
      chk("R7 count load", count_o, c);
      chk("R7 no irq on load", irq_o, 0);
      n = (c + 1) * (s + 1) + 3 * (p + 1) * (s + 1) + 3;
      for (int k = 1; k <= n; k++) begin
         if (hold_at != 0 && k == hold_at) begin
            held = count_o;
            enable = 1'b0;
            for (int h = 0; h < 4; h++) begin
               step();
               chk("R8 count holds", count_o, held);
               chk("R8 irq low", irq_o, 0);
            end
            enable = 1'b1;
         end
         step();
         begin
            int t;
            bit tk;
            t  = k / (s + 1);
            tk = (k % (s + 1)) == 0;
            if (t > c)       chk("R5 reload count", count_o, exp_cnt(c, p, t));
            else if (s == 0) chk("R3 count per cycle", count_o, exp_cnt(c, p, t));
            else             chk("R2 prescaled count", count_o, exp_cnt(c, p, t));
            if (p == 0 && t > c) chk("R6 irq every tick", irq_o, int'(tk && exp_irq_at(c, p, t)));
            else                 chk("R4 irq pulse", irq_o, int'(tk && exp_irq_at(c, p, t)));
         end
      end
   endtask

   initial begin
      repeat (3) step();
      chk("R1 reset count", count_o, 0);
      chk("R1 reset irq", irq_o, 0);
      rst_n = 1'b1;
      step();
      chk("R1 idle count after reset", count_o, 0);
      enable = 1'b1;

      foreach (int_s_list[i]) ;
      for (int si = 0; si < 4; si++)
         for (int pi = 0; pi < 3; pi++)
            for (int ci = 0; ci < 3; ci++) begin
               int sv[4] = '{0, 1, 2, 4};
               int pv[3] = '{0, 1, 3};
               int cv[3] = '{0, 2, 5};
               run_case(sv[si], pv[pi], cv[ci], 0);
            end

      // R8: freeze mid-countdown
      run_case(2, 3, 5, 4);
      run_case(0, 1, 3, 2);

      // R9: period write leaves count untouched, used at next reload
      wr(1, 0);
      wr(2, 2);
      wr(0, 6);
      step(); step();
      chk("R9 before period write", count_o, 4);
      wr(2, 9);
      chk("R9 period write keeps count", count_o, 3);
      step(); step(); step();
      chk("R9 reached zero", count_o, 0);
      chk("R4 irq at zero", irq_o, 1);
      step();
      chk("R9 new period loaded", count_o, 9);

      // R10: scale write restarts the divider
      wr(1, 3);
      wr(2, 0);
      wr(0, 20);
      step(); step();
      wr(1, 3);
      for (int k = 1; k <= 3; k++) begin
         step();
         chk("R10 divider restarted", count_o, 20);
      end
      step();
      chk("R10 first step after restart", count_o, 19);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   int int_s_list[1];

endmodule